// File: doc/BRIEF.md
# Dual-Plane Blink Display Controller

This block holds the state behind a four-digit character display. It keeps one configuration register and two banks of digit codes, called plane P0 and plane P1. For every digit it presents the code to show at this moment. A free-running phase counter, clocked by the display oscillator, divides time into blink half-periods. In the first half-period the display shows plane P0, and in the second it shows plane P1. When blink is switched off, only plane P0 is shown.

A host loads registers through a simple write strobe with an address and a data byte. It reads registers back through a combinational read port. A separate strobe marks the end of a host frame, which is the moment a chip-select line rises. Two configuration actions wait for that strobe: clearing both planes, and restarting the blink timing. Both act once and then drop back to zero. The configuration read also returns the live blink phase in its top bit. A display-enable output combines the shutdown control with an external test input. Serial shifting, multiplexed drive and font lookup sit outside this block.

Top module: `blink_disp_ctrl`

## Requirements
- R1: After reset, reading the configuration register (address 0x04) returns 0x80: phase flag set, shutdown, slow rate, blink off. Every digit register reads 0x20, and dispEn is 0 while testMode is 0.
- R2: Configuration bit 0 is the run control: 0 means shutdown (dispEn=0) and 1 means run (dispEn=1). Digit registers accept writes while in shutdown.
- R3: When testMode is 1, dispEn is 1 whatever configuration bit 0 holds.
- R4: With configuration bit 2 at 0 (slow), the blink phase changes every SLOW_CYCLES clock cycles. The default is 4,000,000.
- R5: With configuration bit 2 at 1 (fast), the blink phase changes every SLOW_CYCLES/2 clock cycles.
- R6: With configuration bit 3 at 0 (blink off), every digit output equals its plane P0 code in both phases, and plane P1 contents have no effect.
- R7: With configuration bit 3 at 1, a digit output equals its plane P0 code while the phase flag is 1 and its plane P1 code while the flag is 0. Each bit therefore acts as a (P1,P0) pair: 00 off, 01 first half only, 10 second half only, 11 always on.
- R8: An endOfFrame pulse while configuration bit 4 is 1 restarts the phase counter and sets the phase flag to 1 (P0 phase). With bit 4 at 0, the pulse leaves the timing alone.
- R9: An endOfFrame pulse while configuration bit 5 is 1 sets every digit register in both planes to 0x00.
- R10: Configuration bits 4 and 5 are one-shot: they read 0 after the endOfFrame pulse that used them, and a later pulse clears and restarts nothing.
- R11: Bit 7 of a configuration read is the live blink phase, equal to blinkPhase: 1 in the P0 half and 0 in the P1 half.
- R12: Digit i of plane P0 is at address 0x20+i and digit i of plane P1 is at 0x40+i. Each reads back the last byte written, and digit i appears at digitOut[8*i+7:8*i].

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; also drives the phase counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Register address for write and read |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one cycle |
| endOfFrame | input | 1 | One-cycle pulse marking chip-select rising |
| testMode | input | 1 | Display test request, forces enable |
| rdData | output | 8 | Combinational read data for regAddr |
| digitOut | output | DIGITS*DW | Active code per digit, digit 0 in low byte |
| blinkPhase | output | 1 | 1 during the P0 half, 0 during the P1 half |
| dispEn | output | 1 | Display enable |

## Verification
Assertions check on every cycle that:
- the phase counter stays below its slow limit;
- a restart pulse leaves the counter at zero in the P0 phase;
- the phase flag holds between rollovers;
- the one-shot bits read zero after a frame end;
- a clear pulse leaves every plane register at zero;
- test mode forces the display enable.

Some behaviour only the bench scenarios can show. These are the exact half-period lengths in both rates, and the plane selection with blink enabled and disabled. The bench also covers writes accepted in shutdown, and the fact that a second frame end neither clears nor restarts anything.

// File: rtl/blink_pkg.sv
package blink_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // wipe both planes this cycle
    logic showP1;    // present plane P1 codes
  } dpStrobe_t;

  // Configuration bit positions
  localparam int CfgRun   = 0;
  localparam int CfgFast  = 2;
  localparam int CfgBlink = 3;
  localparam int CfgSync  = 4;
  localparam int CfgClr   = 5;

  // Register addresses
  localparam logic [7:0] AddrCfg  = 8'h04;
  localparam logic [7:0] AddrP0   = 8'h20;
  localparam logic [7:0] AddrP1   = 8'h40;
  localparam logic [7:0] BlankCode = 8'h20;
endpackage

// File: rtl/blink_ctrl.sv
module blink_ctrl
  import blink_pkg::*;
#(
  parameter int SLOW_CYCLES = 4000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] regAddr,
  input  logic [7:0] wrData,
  input  logic       wrEn,
  input  logic       endOfFrame,
  input  logic       testMode,
  output logic [7:0] cfgRead,
  output logic       blinkPhase,
  output logic       dispEn,
  output dpStrobe_t  strobe
);
  localparam int CW = $clog2(SLOW_CYCLES + 1);
  localparam logic [CW-1:0] SlowLim = CW'(SLOW_CYCLES);
  localparam logic [CW-1:0] FastLim = CW'(SLOW_CYCLES / 2);

  logic [6:0]    cfgReg;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          phase;
  logic          cfgWr;
  logic          doSync;
  logic          wrap;

  assign cfgWr  = wrEn && (regAddr == AddrCfg);
  assign doSync = endOfFrame && cfgReg[CfgSync];
  assign lim    = cfgReg[CfgFast] ? FastLim : SlowLim;
  assign wrap   = (cnt >= lim - CW'(1));

  // Config register; sync/clear bits are consumed by the frame end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgReg <= '0;
    end else if (cfgWr) begin
      cfgReg <= wrData[6:0];
    end else if (endOfFrame) begin
      cfgReg[CfgSync] <= 1'b0;
      cfgReg[CfgClr]  <= 1'b0;
    end
  end

  // Blink phase divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (doSync) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign strobe.clearAll = endOfFrame && cfgReg[CfgClr];
  assign strobe.showP1   = cfgReg[CfgBlink] && !phase;
  assign cfgRead         = {phase, cfgReg};
  assign blinkPhase      = phase;
  assign dispEn          = cfgReg[CfgRun] | testMode;

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < SlowLim);
  assert_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    doSync |=> (cnt == '0) && phase);
  assert_oneshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (endOfFrame && !cfgWr) |=> (cfgReg[CfgSync] == 1'b0) && (cfgReg[CfgClr] == 1'b0));
  assert_phase_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!doSync && !wrap) |=> $stable(phase));
  assert_test_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    testMode |-> dispEn);
endmodule

// File: rtl/blink_data.sv
module blink_data
  import blink_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           regAddr,
  input  logic [7:0]           wrData,
  input  logic                 wrEn,
  input  dpStrobe_t            strobe,
  output logic [DIGITS*DW-1:0] digitOut,
  output logic [7:0]           dpRead
);
  logic [DW-1:0] p0 [DIGITS];
  logic [DW-1:0] p1 [DIGITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DIGITS; i++) begin
        p0[i] <= DW'(BlankCode);
        p1[i] <= DW'(BlankCode);
      end
    end else if (strobe.clearAll) begin
      for (int i = 0; i < DIGITS; i++) begin
        p0[i] <= '0;
        p1[i] <= '0;
      end
    end else if (wrEn) begin
      for (int i = 0; i < DIGITS; i++) begin
        if (regAddr == AddrP0 + 8'(i)) p0[i] <= DW'(wrData);
        if (regAddr == AddrP1 + 8'(i)) p1[i] <= DW'(wrData);
      end
    end
  end

  always_comb begin
    dpRead = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (regAddr == AddrP0 + 8'(i)) dpRead = 8'(p0[i]);
      if (regAddr == AddrP1 + 8'(i)) dpRead = 8'(p1[i]);
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_out
    assign digitOut[g*DW +: DW] = strobe.showP1 ? p1[g] : p0[g];

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.clearAll |=> (p0[g] == '0) && (p1[g] == '0));
  end
endmodule

// File: rtl/blink_disp_ctrl.sv
module blink_disp_ctrl
  import blink_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int DW          = 8,
  parameter int SLOW_CYCLES = 4000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           regAddr,
  input  logic [7:0]           wrData,
  input  logic                 wrEn,
  input  logic                 endOfFrame,
  input  logic                 testMode,
  output logic [7:0]           rdData,
  output logic [DIGITS*DW-1:0] digitOut,
  output logic                 blinkPhase,
  output logic                 dispEn
);
  dpStrobe_t  strobe;
  logic [7:0] cfgRead;
  logic [7:0] dpRead;

  blink_ctrl #(.SLOW_CYCLES(SLOW_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .wrData(wrData),
    .wrEn(wrEn), .endOfFrame(endOfFrame), .testMode(testMode),
    .cfgRead(cfgRead), .blinkPhase(blinkPhase), .dispEn(dispEn),
    .strobe(strobe)
  );

  blink_data #(.DIGITS(DIGITS), .DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .wrData(wrData),
    .wrEn(wrEn), .strobe(strobe), .digitOut(digitOut), .dpRead(dpRead)
  );

  assign rdData = (regAddr == AddrCfg) ? cfgRead : dpRead;
endmodule

// File: tb/sim_blink_disp_ctrl.sv
module sim_blink_disp_ctrl;
  localparam int DIGITS = 4;
  localparam int DW     = 8;
  localparam int SLOW   = 20;
  localparam int FAST   = SLOW / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic wrEn = 1'b0;
  logic endOfFrame = 1'b0;
  logic testMode = 1'b0;
  logic [7:0] rdData;
  logic [DIGITS*DW-1:0] digitOut;
  logic blinkPhase;
  logic dispEn;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  blink_disp_ctrl #(.DIGITS(DIGITS), .DW(DW), .SLOW_CYCLES(SLOW)) u0 (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .wrData(wrData),
    .wrEn(wrEn), .endOfFrame(endOfFrame), .testMode(testMode),
    .rdData(rdData), .digitOut(digitOut), .blinkPhase(blinkPhase),
    .dispEn(dispEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic frameEnd();
    @(negedge clk);
    endOfFrame = 1'b1;
    @(negedge clk);
    endOfFrame = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h04, d); check("R1 cfg", d, 8'h80);
    for (int i = 0; i < DIGITS; i++) begin
      rd(8'h20 + 8'(i), d); check("R1 p0", d, 8'h20);
      rd(8'h40 + 8'(i), d); check("R1 p1", d, 8'h20);
    end
    check("R1 dispEn", dispEn, 0);
  endtask

  task automatic t_shutdown_test();
    logic [7:0] d;
    wr(8'h21, 8'h5A);
    rd(8'h21, d); check("R2 write in shutdown", d, 8'h5A);
    check("R12 digit1 out", digitOut[15:8], 8'h5A);
    testMode = 1'b1; #1;
    check("R3 test overrides shutdown", dispEn, 1);
    testMode = 1'b0; #1;
    check("R2 shutdown dispEn", dispEn, 0);
    wr(8'h04, 8'h01);
    check("R2 run dispEn", dispEn, 1);
  endtask

  // Restart timing, then measure half-period length
  task automatic t_rate(input logic fast, input int n, input string req);
    wr(8'h04, {3'b000, 1'b1, 1'b0, fast, 2'b01});
    frameEnd();
    check({req, " phase after resync R8"}, blinkPhase, 1);
    repeat (n - 1) @(negedge clk);
    check({req, " phase held"}, blinkPhase, 1);
    @(negedge clk);
    check({req, " phase toggled"}, blinkPhase, 0);
    regAddr = 8'h04; #1;
    check("R11 readback bit7", rdData[7], 0);
  endtask

  task automatic t_blink();
    wr(8'h20, 8'hA5);
    wr(8'h40, 8'h3C);
    // blink enabled
    wr(8'h04, 8'h19);
    frameEnd();
    check("R7 P0 half", digitOut[7:0], 8'hA5);
    repeat (SLOW) @(negedge clk);
    check("R7 P1 half", digitOut[7:0], 8'h3C);
    // blink disabled
    wr(8'h04, 8'h11);
    frameEnd();
    repeat (SLOW) @(negedge clk);
    check("R6 phase is P1", blinkPhase, 0);
    check("R6 P1 ignored", digitOut[7:0], 8'hA5);
  endtask

  task automatic t_nosync();
    wr(8'h04, 8'h01);
    frameEnd();
    wait (blinkPhase == 1'b0);
    @(negedge clk);
    frameEnd();
    check("R8 no restart without bit4", blinkPhase, 0);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(8'h43, 8'h77);
    wr(8'h04, 8'h21);
    rd(8'h43, d); check("R9 before frame end", d, 8'h77);
    rd(8'h04, d); check("R10 bit5 pending", d[5], 1);
    frameEnd();
    for (int i = 0; i < DIGITS; i++) begin
      rd(8'h20 + 8'(i), d); check("R9 p0 cleared", d, 8'h00);
      rd(8'h40 + 8'(i), d); check("R9 p1 cleared", d, 8'h00);
    end
    rd(8'h04, d); check("R10 bit5 consumed", d[5], 0);
    wr(8'h22, 8'h42);
    frameEnd();
    rd(8'h22, d); check("R10 no second clear", d, 8'h42);
  endtask

  initial begin : watchdog
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shutdown_test();
    t_rate(1'b0, SLOW, "R4 slow");
    t_rate(1'b1, FAST, "R5 fast");
    t_blink();
    t_nosync();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule